// File: doc/BRIEF.md
# Sixteen-Pin I/O Port with Peripheral Function Select

This block is one general-purpose I/O port. Each pin is either a software-controlled GPIO or is handed to one of four on-chip peripheral signals. For GPIO pins the port holds an output latch and a direction bit. Both are changed only by write-one-to-set and write-one-to-clear addresses, so two agents can each change their own pins without a read-modify-write. A separate input-enable bit per pin gates the synchronized pad value. The gated value goes to a read-back register and to a pin interrupt controller.

A host drives a simple single-cycle register bus. Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. Peripheral signals come in as two flat vectors, in which function k of pin n sits at bit k*NPINS+n. The pad drivers take `pad_out` and `pad_oe`.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset every pin is a GPIO input. Output latch, direction, input enable, function enable and mux fields are all zero, so `pad_oe`, `pad_out` and `irq_bits` are zero.
- R2: A write to address 1 sets the output latch bits where the write data is 1. A write to address 2 clears them. The other bits keep their value. Reading address 1 or 2 returns the latch.
- R3: A write to address 3 sets direction bits where the data is 1, and a write to address 4 clears them. A direction bit of 1 means output. Reading address 3 or 4 returns the direction.
- R4: For a pin whose function-enable bit is 0, `pad_oe` equals its direction bit and `pad_out` equals its latch bit.
- R5: For a pin whose function-enable bit is 1, the 2-bit field at bits 2n+1:2n of the mux register (address 7) picks function k. Then `pad_out[n]` is `func_out[k*16+n]` and `pad_oe[n]` is `func_oe[k*16+n]`.
- R6: A pad value reaches `irq_bits` and the data read after exactly two clock edges. `func_in` carries the synchronized pad value for function-enabled pins and 0 for the others.
- R7: When a pin's input-enable bit is 0, its `irq_bits` bit is 0. Its data read bit is also 0 if the pin is not an output.
- R8: Reading address 0 returns the latch for output pins, the synchronized pad for input-enabled non-output pins, and 0 otherwise.
- R9: Address 5 (input enable) and address 6 (function enable) are plain 16-bit read/write registers that read back with the upper 16 bits zero. Address 7 is a plain 32-bit read/write register.
- R10: Writes to address 0 and to addresses 8 to 15 change no register. Reads of addresses 8 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 16 | Raw pad input levels |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables |
| func_out | input | 64 | Peripheral output signals, function k of pin n at k*16+n |
| func_oe | input | 64 | Peripheral output enables, same layout |
| func_in | output | 16 | Synchronized pad value to peripherals, function pins only |
| irq_bits | output | 16 | Gated, synchronized inputs to the pin interrupt controller |

## Verification
The case that matters is a pad edge that arrives in the same cycle as a write that clears that pin's input enable. The bench sets all input enables, raises every pad at the same negative edge as it writes an input-enable value with bit 0 cleared, and then samples after each of the next two edges. Bit 0 must stay 0 throughout. The other bits must still be 0 after one edge and must be 1 after the second. A second overlap is a latch write on an output pin while its pad is held at the opposite level. The bench expects the read to follow the latch and not the pad.

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int NPINS = 16,
  parameter int NFUNC = 4,
  parameter int SYNC  = 2,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic [NPINS-1:0]       pad_in,
  output logic [NPINS-1:0]       pad_out,
  output logic [NPINS-1:0]       pad_oe,
  input  logic [NFUNC*NPINS-1:0] func_out,
  input  logic [NFUNC*NPINS-1:0] func_oe,
  output logic [NPINS-1:0]       func_in,
  output logic [NPINS-1:0]       irq_bits
);
  localparam int SELW = (NFUNC > 1) ? $clog2(NFUNC) : 1;
  localparam int MW   = NPINS * SELW;
  localparam logic [AW-1:0] A_PIN  = AW'(0);
  localparam logic [AW-1:0] A_DSET = AW'(1);
  localparam logic [AW-1:0] A_DCLR = AW'(2);
  localparam logic [AW-1:0] A_OSET = AW'(3);
  localparam logic [AW-1:0] A_OCLR = AW'(4);
  localparam logic [AW-1:0] A_INEN = AW'(5);
  localparam logic [AW-1:0] A_FEN  = AW'(6);
  localparam logic [AW-1:0] A_MUX  = AW'(7);

  logic [NPINS-1:0] lat_q, dir_q, inen_q, fen_q;
  logic [MW-1:0]    mux_q;
  logic [NPINS-1:0] sync_q [SYNC];
  logic [NPINS-1:0] pad_s, pin_rd;
  logic [NPINS-1:0] wbits;

  assign wbits = bus_wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      dir_q  <= '0;
      inen_q <= '0;
      fen_q  <= '0;
      mux_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DSET:  lat_q  <= lat_q | wbits;
        A_DCLR:  lat_q  <= lat_q & ~wbits;
        A_OSET:  dir_q  <= dir_q | wbits;
        A_OCLR:  dir_q  <= dir_q & ~wbits;
        A_INEN:  inen_q <= wbits;
        A_FEN:   fen_q  <= wbits;
        A_MUX:   mux_q  <= bus_wdata[MW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pad_in;
      for (int s = 1; s < SYNC; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign pad_s    = sync_q[SYNC-1];
  assign irq_bits = pad_s & inen_q;
  assign func_in  = pad_s & fen_q;
  assign pin_rd   = (dir_q & lat_q) | (~dir_q & irq_bits);

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic [SELW-1:0] sel;
    assign sel        = mux_q[n*SELW +: SELW];
    assign pad_out[n] = fen_q[n] ? func_out[int'(sel)*NPINS + n] : lat_q[n];
    assign pad_oe[n]  = fen_q[n] ? func_oe[int'(sel)*NPINS + n]  : dir_q[n];
  end

  always_comb begin
    case (bus_addr)
      A_PIN:          bus_rdata = DW'(pin_rd);
      A_DSET, A_DCLR: bus_rdata = DW'(lat_q);
      A_OSET, A_OCLR: bus_rdata = DW'(dir_q);
      A_INEN:         bus_rdata = DW'(inen_q);
      A_FEN:          bus_rdata = DW'(fen_q);
      A_MUX:          bus_rdata = DW'(mux_q);
      default:        bus_rdata = '0;
    endcase
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && irq_bits == '0));

  assert_latch_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DSET) |=> ((lat_q & $past(wbits)) == $past(wbits)));

  assert_latch_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DCLR) |=> ((lat_q & $past(wbits)) == '0));

  assert_dir_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_OCLR) |=> ((dir_q & $past(wbits)) == '0));

  assert_gpio_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~fen_q & ~dir_q) == '0);

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_bits & ~inen_q) == '0);

  assert_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_PIN || bus_addr > A_MUX)) |=>
      ($stable(lat_q) && $stable(dir_q) && $stable(inen_q) && $stable(fen_q) && $stable(mux_q)));
endmodule

// File: tb/sim_gpio_mux_port.sv
module sim_gpio_mux_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = 0;
  logic [15:0] pad_out, pad_oe, func_in, irq_bits;
  logic [63:0] func_out = 0, func_oe = 0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_lat = 0, m_dir = 0, m_inen = 0, m_fen = 0;
  logic [31:0] m_mux = 0;

  gpio_mux_port u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .func_out(func_out), .func_oe(func_oe), .func_in(func_in),
    .irq_bits(irq_bits));

  always #10 clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [3:0] a);
    case (a)
      4'd0: return {16'h0, (m_dir & m_lat) | (~m_dir & m_inen & pad_in)};
      4'd1, 4'd2: return {16'h0, m_lat};
      4'd3, 4'd4: return {16'h0, m_dir};
      4'd5: return {16'h0, m_inen};
      4'd6: return {16'h0, m_fen};
      4'd7: return m_mux;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [15:0] exp_pad(bit want_oe);
    logic [15:0] r;
    for (int n = 0; n < 16; n++) begin
      int k;
      k = int'(m_mux[2*n +: 2]);
      if (m_fen[n]) r[n] = want_oe ? func_oe[k*16+n] : func_out[k*16+n];
      else          r[n] = want_oe ? m_dir[n] : m_lat[n];
    end
    return r;
  endfunction

  function automatic void model_write(logic [3:0] a, logic [31:0] d);
    case (a)
      4'd1: m_lat = m_lat | d[15:0];
      4'd2: m_lat = m_lat & ~d[15:0];
      4'd3: m_dir = m_dir | d[15:0];
      4'd4: m_dir = m_dir & ~d[15:0];
      4'd5: m_inen = d[15:0];
      4'd6: m_fen = d[15:0];
      4'd7: m_mux = d;
      default: ;
    endcase
  endfunction

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    bus_wr = 0;
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < 16; a++) begin
      bus_addr = 4'(a);
      #1;
      check({tag, " read R2 R3 R8 R9 R10"}, bus_rdata, exp_read(4'(a)));
    end
    check({tag, " pad_out R4 R5"}, pad_out, exp_pad(0));
    check({tag, " pad_oe R4 R5"}, pad_oe, exp_pad(1));
    check({tag, " irq_bits R7"}, irq_bits, pad_in & m_inen);
    check({tag, " func_in R6"}, func_in, pad_in & m_fen);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7131));
    @(negedge clk); @(negedge clk);
    #1;
    // R1: state held under reset
    check("R1 pad_oe", pad_oe, 16'h0);
    check("R1 pad_out", pad_out, 16'h0);
    rst_n = 1;
    idle(2);
    check_all("R1 after reset");

    // R2 / R3 directed set and clear
    bus_write(4'd1, 32'h0000_A5A5);
    bus_write(4'd2, 32'h0000_0005);
    bus_addr = 4'd1; #1;
    check("R2 latch set/clear", bus_rdata, 32'h0000_A5A0);
    bus_write(4'd3, 32'h0000_00FF);
    bus_write(4'd4, 32'h0000_000F);
    bus_addr = 4'd4; #1;
    check("R3 dir set/clear", bus_rdata, 32'h0000_00F0);
    check("R4 gpio oe", pad_oe, 16'h00F0);
    check("R4 gpio out", pad_out, 16'hA5A0);

    // R8: output pin reads latch although the pad is opposite
    pad_in = 16'h0F5F;
    bus_write(4'd5, 32'h0000_FFFF);
    idle(2);
    bus_addr = 4'd0; #1;
    check("R8 pin read", bus_rdata, {16'h0, (16'h00F0 & 16'hA5A0) | (16'hFF0F & 16'h0F5F)});

    // R5: pin 3 to function 2, pin 9 to function 3
    func_out = 64'h0;
    func_out[2*16+3] = 1'b1;
    func_oe[3*16+9] = 1'b1;
    bus_write(4'd7, (32'd2 << 6) | (32'd3 << 18));
    bus_write(4'd6, 32'h0000_0208);
    check("R5 func out pin3", {63'h0, pad_out[3]}, 64'h1);
    check("R5 func oe pin9", {63'h0, pad_oe[9]}, 64'h1);
    check("R5 func oe pin3", {63'h0, pad_oe[3]}, 64'h0);

    // R6 latency and R7 same-cycle gating
    bus_write(4'd5, 32'h0000_FFFF);
    pad_in = 16'h0000;
    idle(3);
    pad_in = 16'hFFFF;
    bus_write(4'd5, 32'h0000_FFFE);
    check("R7 same cycle irq after 1 edge", irq_bits, 16'h0000);
    idle(1);
    check("R6 R7 irq after 2 edges", irq_bits, 16'hFFFE);
    check("R6 func_in", func_in, 16'h0208);

    // R10 ignored writes
    bus_write(4'd0, 32'hFFFF_FFFF);
    bus_write(4'd9, 32'hFFFF_FFFF);
    bus_write(4'd15, 32'h0);
    check_all("R10 ignored");

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      a = 4'($urandom % 16);
      func_out = {$urandom, $urandom};
      func_oe  = {$urandom, $urandom};
      bus_write(a, $urandom);
      if (i % 25 == 0) begin
        pad_in = 16'($urandom);
        idle(3);
      end
      check_all("random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule